// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of general-purpose pins that sits on a simple word-addressed register bus. Software sets each pin's direction, writes an output latch that drives the pads, and reads back two separate views. The first view is the pin level seen through input synchronizers. The second view is the contents of the output latch. The level view can lag a write by a few cycles, so the latch view is the one to use when software needs to know what it last wrote. The pad inputs come already filtered from a neighbouring block. This bank only synchronizes them and watches them.

Each pin has its own interrupt detector. The detector is configured by three parallel per-pin trigger registers, and it can fire on a rising edge, a falling edge, both edges, a low level or a high level. A hit sets a sticky status bit. Software clears a status bit by writing a one to it. One interrupt output is raised while any status bit that is also enabled is set.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0. This makes all pins inputs (pad_oe = 0), drives pad_out to 0, disables all interrupts and holds irq_out at 0.
- R2: A write to word address 1 sets the direction register, and the bus reads it back. Bit value 1 makes that pin an output, so pad_oe equals the direction register from the cycle after the write.
- R3: A write to word address 0 loads the output latch, which drives pad_out from the next cycle. A read of word address 2 returns the latch. Writes to address 2 are ignored.
- R4: A read of word address 0 returns pin_in after a two-flop synchronizer, whatever the pin's direction. A change in pin_in is seen by the read after the second rising edge and not after the first.
- R5: The trigger code per pin is (bit of address 6, bit of address 5, bit of address 4). Code 000 and code 100 select falling edge. Code 001 selects rising edge. Codes 101 and 111 select both edges. A matching edge sets the status bit at the third rising edge after pin_in changes.
- R6: Code 010 and code 110 select level low, and code 011 selects level high. While the level is active, the status bit is set again on every cycle, including the cycle in which software clears it.
- R7: The status register is at word address 7. Writing 1 to a bit clears that bit. Writing 0 leaves it unchanged. A new hit in the same cycle as a clear wins over the clear.
- R8: Status bits latch whether or not they are enabled. The interrupt enable register is at word address 3. irq_out is 1 exactly when some status bit and the matching enable bit are both 1, and it follows enable writes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Read data, combinational from bus_addr |
| pin_in | input | NPIN | Filtered pad inputs |
| pad_out | output | NPIN | Output latch to pads |
| pad_oe | output | NPIN | Pad output enable, 1 = drive |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bound assertions are checked on every cycle. They check that pad_oe and pad_out take the written values one cycle after each write. They check that status bits never drop except on a status write, and that a status write never drops a bit whose write-data bit was 0. They also check that a newly set status bit on an edge-type pin always follows a change between the last two synchronized samples, and that irq_out never rises without an enable bit. The bench scenarios are what show the rest. They sweep all eight trigger codes across pin transition patterns, and they show the exact cycle of synchronizer and status latency. They also show that a level pin sets its status bit again right after a clear, that the value view differs from the latch view while a pin is an output, and that an enable write gates the interrupt output.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_en,
  input  logic            bus_we,
  input  logic [2:0]      bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            irq_out
);

  localparam logic [2:0] A_LEVEL = 3'd0;
  localparam logic [2:0] A_DIR   = 3'd1;
  localparam logic [2:0] A_LATRB = 3'd2;
  localparam logic [2:0] A_IEN   = 3'd3;
  localparam logic [2:0] A_TRG0  = 3'd4;
  localparam logic [2:0] A_TRG1  = 3'd5;
  localparam logic [2:0] A_TRG2  = 3'd6;
  localparam logic [2:0] A_STS   = 3'd7;

  logic [NPIN-1:0] lat_q, dir_q, ien_q, trg0_q, trg1_q, trg2_q, sts_q;
  logic [NPIN-1:0] sy1_q, smp_q, prv_q;
  logic [NPIN-1:0] hit, clr;

  wire wr = bus_en & bus_we;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lat_q  <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      trg0_q <= '0;
      trg1_q <= '0;
      trg2_q <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_LEVEL: lat_q  <= bus_wdata;
        A_DIR:   dir_q  <= bus_wdata;
        A_IEN:   ien_q  <= bus_wdata;
        A_TRG0:  trg0_q <= bus_wdata;
        A_TRG1:  trg1_q <= bus_wdata;
        A_TRG2:  trg2_q <= bus_wdata;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1_q <= '0;
      smp_q <= '0;
      prv_q <= '0;
    end else begin
      sy1_q <= pin_in;
      smp_q <= sy1_q;
      prv_q <= smp_q;
    end

  for (genvar i = 0; i < NPIN; i++) begin : g_det
    wire rise = smp_q[i] & ~prv_q[i];
    wire fall = ~smp_q[i] & prv_q[i];
    always_comb begin
      if (trg2_q[i] & trg0_q[i])
        hit[i] = rise | fall;
      else if (trg1_q[i])
        hit[i] = trg0_q[i] ? smp_q[i] : ~smp_q[i];
      else
        hit[i] = trg0_q[i] ? rise : fall;
    end
  end

  assign clr = (wr && bus_addr == A_STS) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr) | hit;

  always_comb
    case (bus_addr)
      A_LEVEL: bus_rdata = smp_q;
      A_DIR:   bus_rdata = dir_q;
      A_LATRB: bus_rdata = lat_q;
      A_IEN:   bus_rdata = ien_q;
      A_TRG0:  bus_rdata = trg0_q;
      A_TRG1:  bus_rdata = trg1_q;
      A_TRG2:  bus_rdata = trg2_q;
      default: bus_rdata = sts_q;
    endcase

  assign pad_out = lat_q;
  assign pad_oe  = dir_q;
  assign irq_out = |(sts_q & ien_q);

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPIN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_en,
  input logic            bus_we,
  input logic [2:0]      bus_addr,
  input logic [NPIN-1:0] bus_wdata,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic            irq_out,
  input logic [NPIN-1:0] sts,
  input logic [NPIN-1:0] ien,
  input logic [NPIN-1:0] trg1,
  input logic [NPIN-1:0] smp,
  input logic [NPIN-1:0] prv
);

  wire sts_wr = bus_en && bus_we && bus_addr == 3'd7;

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == 3'd1) |=> pad_oe == $past(bus_wdata));

  a_r3_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == 3'd0) |=> pad_out == $past(bus_wdata));

  a_r7_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |=> ((sts & $past(sts & ~bus_wdata)) == $past(sts & ~bus_wdata)));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_wr |=> ((sts & $past(sts)) == $past(sts)));

  a_r5_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & ~$past(sts) & ~$past(trg1) & ~$past(smp ^ prv)) == '0));

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (ien != '0));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .irq_out(irq_out), .sts(sts_q), .ien(ien_q),
  .trg1(trg1_q), .smp(smp_q), .prv(prv_q)
);

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;
  localparam int N = 32;
  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [N-1:0] bus_wdata = 0, pin_in = 0;
  logic [N-1:0] bus_rdata, pad_out, pad_oe;
  logic irq_out;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  gpio_irq_bank #(.NPIN(N)) uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out));

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [N-1:0] exp_edge(input logic [2:0] c, input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N-1:0] r = b & ~a, f = a & ~b;
    if (c[2] & c[0]) return r | f;
    if (c[1]) return '0;
    return c[0] ? r : f;
  endfunction

  function automatic logic [N-1:0] lvl(input logic [2:0] c, input logic [N-1:0] v);
    if ((c[2] & c[0]) || !c[1]) return '0;
    return c[0] ? v : ~v;
  endfunction

  initial begin
    #(8ns * 100000);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] d;
    logic [N-1:0] pa [3] = '{32'h0F0F_3C3C, 32'hFFFF_0000, 32'h1234_5678};
    logic [N-1:0] pb [3] = '{32'h33CC_55AA, 32'h00FF_00FF, 32'hEDCB_A987};
    wait_cyc(3);
    rst_n = 1;
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reg%0d", a), d, '0);
    end
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 irq_out", {31'd0, irq_out}, '0);

    // R2: direction
    wr(3'd1, 32'hA5A5_0F0F);
    chk("R2 pad_oe", pad_oe, 32'hA5A5_0F0F);
    rd(3'd1, d); chk("R2 dir readback", d, 32'hA5A5_0F0F);

    // R3: latch and readback
    wr(3'd0, 32'hDEAD_BEEF);
    chk("R3 pad_out", pad_out, 32'hDEAD_BEEF);
    rd(3'd2, d); chk("R3 latch readback", d, 32'hDEAD_BEEF);
    wr(3'd2, 32'h0);
    rd(3'd2, d); chk("R3 readback ignores write", d, 32'hDEAD_BEEF);

    // R4: value view is synchronized pin, not latch
    @(negedge clk); pin_in = 32'h1357_9BDF; bus_addr = 3'd0;
    @(negedge clk); #1 chk("R4 after one edge", bus_rdata, 32'h0);
    @(negedge clk); #1 chk("R4 after two edges", bus_rdata, 32'h1357_9BDF);
    rd(3'd2, d); chk("R4 latch differs", d, 32'hDEAD_BEEF);
    @(negedge clk); pin_in = 0;
    wait_cyc(4);
    wr(3'd7, '1);

    // R5: status latency, default falling edge
    @(negedge clk); pin_in = 32'h1; wait_cyc(4); wr(3'd7, '1);
    @(negedge clk); pin_in = 32'h0; bus_addr = 3'd7;
    @(negedge clk); @(negedge clk); #1 chk("R5 before third edge", bus_rdata, '0);
    @(negedge clk); #1 chk("R5 at third edge", bus_rdata, 32'h1);

    // R7: zero write keeps, one write clears only that bit
    @(negedge clk); pin_in = 32'h6; wait_cyc(4);
    @(negedge clk); pin_in = 32'h0; wait_cyc(4);
    rd(3'd7, d); chk("R7 setup", d, 32'h7);
    wr(3'd7, 32'h0); rd(3'd7, d); chk("R7 zero write", d, 32'h7);
    wr(3'd7, 32'h2); rd(3'd7, d); chk("R7 clear one bit", d, 32'h5);

    // R8: enable gating
    chk("R8 masked", {31'd0, irq_out}, '0);
    wr(3'd3, 32'h2); chk("R8 disabled bit", {31'd0, irq_out}, '0);
    wr(3'd3, 32'h4); chk("R8 enabled bit", {31'd0, irq_out}, 32'h1);
    wr(3'd3, 32'h0); chk("R8 enable cleared", {31'd0, irq_out}, '0);
    wr(3'd7, '1);

    // R5/R6: sweep of trigger codes and transition patterns
    for (int c = 0; c < 8; c++) begin
      wr(3'd4, c[0] ? '1 : '0);
      wr(3'd5, c[1] ? '1 : '0);
      wr(3'd6, c[2] ? '1 : '0);
      for (int p = 0; p < 3; p++) begin
        @(negedge clk); pin_in = pa[p]; wait_cyc(4);
        wr(3'd7, '1);
        @(negedge clk); pin_in = pb[p]; wait_cyc(4);
        rd(3'd7, d);
        chk($sformatf("R5 R6 code%0d pat%0d", c, p), d,
            exp_edge(3'(c), pa[p], pb[p]) | lvl(3'(c), pa[p]) | lvl(3'(c), pb[p]));
        wr(3'd7, '1);
        rd(3'd7, d);
        chk($sformatf("R6 reset after clear code%0d pat%0d", c, p), d, lvl(3'(c), pb[p]));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule